// File: doc/BRIEF.md
# Programmable Even-Ratio Output Divider Bank

This block takes one fast input clock, standing in for an oscillator, and produces five divided clocks from it. Software writes each divider's ratio and polarity. The ratio must be even and lie between 2 and 64. A configuration is captured into shadow registers on a single load strobe. A running divider does not switch to a new setting in the middle of a period. It picks the setting up when its counter wraps, so no shortened pulse reaches the output.

The high time of each output follows a fixed rule. A ratio of 2, or any multiple of 4, gives an exact half-period high. Any other even ratio is high for one input cycle less than half the period. An inverted output swaps the high and low times. One divider can be chosen as the feedback tap and is copied to a separate output. That divider still drives its own output as well.

The block checks the settings it holds. Each divider has an error flag for an illegal ratio, and the divider's output is held low while that ratio is active. A shared configuration flag is raised in three cases: the feedback multiplier is out of range, its product with the tap ratio exceeds 64, or the tap select names no divider.

Top module: `even_div_bank`

## Requirements
- R1: With a legal ratio R (even, 2 to 64), divider output k repeats every R input-clock cycles.
- R2: Each divider runs from its own ratio and polarity settings and is unaffected by the settings of the other four.
- R3: For a non-inverted output with ratio R, the high time is R/2 cycles when R is 2 or a multiple of 4. Otherwise it is R/2-1 cycles, so ratio 14 is high for 6 of 14 cycles.
- R4: When the polarity bit of divider k is 1, its high time is R minus the R3 high time, so ratio 14 is high for 8 of 14 cycles.
- R5: A ratio that is odd, below 2 or above 64 sets div_err_o[k] in the cycle after it is loaded. Once it becomes active, output k is held low.
- R6: A newly loaded ratio or polarity takes effect only when divider k completes its current period. The old waveform runs unchanged until then.
- R7: While rst_ni is low, all outputs and flags are 0. The reset setting is ratio 2, not inverted, tap 0, multiplier 1. On the first rising edge after release, all five outputs go high together.
- R8: For a tap select value from 0 to 4, fb_o equals clk_o at that index, and that divider still drives its own clk_o bit.
- R9: cfg_err_o is 1 in any of three cases: the multiplier is 0 or above 32, the multiplier times the ratio of the tapped divider exceeds 64, or the tap select is 5 to 7. For a select of 5 to 7, fb_o is 0.
- R10: The configuration inputs are sampled only on a rising edge where cfg_load_i is 1. At all other times they have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ratio_i | input | 35 | Five 7-bit ratios; divider k uses bits [7k+6:7k] |
| cfg_inv_i | input | 5 | Polarity per divider, 1 = inverted |
| cfg_fb_sel_i | input | 3 | Feedback tap select, 0 to 4 legal |
| cfg_fb_mult_i | input | 6 | Feedback multiplier, 1 to 32 legal |
| cfg_load_i | input | 1 | Capture strobe for all configuration inputs |
| clk_o | output | 5 | Divided outputs |
| fb_o | output | 1 | Copy of the tapped divider output |
| div_err_o | output | 5 | Illegal-ratio flag per divider (loaded setting) |
| cfg_err_o | output | 1 | Feedback configuration error flag |

## Verification
The assertions assume that the configuration inputs are steady around every rising edge where cfg_load_i is high. They also assume that reset is released between clock edges. The bench changes all inputs only on falling edges, and it keeps every strobe to exactly one cycle. It waits at least one full period of the slowest divider after each load before it measures a waveform. The one exception is the test that loads deliberately in mid-period to watch the old waveform finish.

// File: rtl/even_div_pkg.sv
package even_div_pkg;
  localparam int RATIO_W     = 7;
  localparam int MAX_RATIO   = 64;
  localparam int MULT_W      = 6;
  localparam int MAX_MULT    = 32;
  localparam int FB_PROD_MAX = 64;
  localparam int PROD_W      = RATIO_W + MULT_W;

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [MULT_W-1:0]  mult_t;

  localparam ratio_t RATIO_RST = ratio_t'(2);

  function automatic logic ratio_ok(ratio_t r);
    return !r[0] && (r >= ratio_t'(2)) && (r <= ratio_t'(MAX_RATIO));
  endfunction

  // half period, one cycle shorter when ratio/2 is odd (except ratio 2)
  function automatic ratio_t high_len(ratio_t r);
    ratio_t half;
    half = r >> 1;
    if (r == ratio_t'(2) || r[1:0] == 2'b00) return half;
    return half - ratio_t'(1);
  endfunction
endpackage

// File: rtl/even_div_cfg.sv
module even_div_cfg
  import even_div_pkg::*;
#(
  parameter int NUM_DIV = 5,
  parameter int SEL_W   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  ratio_t [NUM_DIV-1:0]       ratio_i,
  input  logic   [NUM_DIV-1:0]       inv_i,
  input  logic   [SEL_W-1:0]         sel_i,
  input  mult_t                      mult_i,
  output ratio_t [NUM_DIV-1:0]       ratio_o,
  output logic   [NUM_DIV-1:0]       inv_o,
  output logic   [SEL_W-1:0]         sel_o,
  output logic   [NUM_DIV-1:0]       div_err_o,
  output logic                       cfg_err_o
);
  ratio_t [NUM_DIV-1:0] ratio_q;
  logic   [NUM_DIV-1:0] inv_q;
  logic   [SEL_W-1:0]   sel_q;
  mult_t                mult_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= {NUM_DIV{RATIO_RST}};
      inv_q   <= '0;
      sel_q   <= '0;
      mult_q  <= mult_t'(1);
    end else if (load_i) begin
      ratio_q <= ratio_i;
      inv_q   <= inv_i;
      sel_q   <= sel_i;
      mult_q  <= mult_i;
    end
  end

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_err
    assign div_err_o[k] = !ratio_ok(ratio_q[k]);
  end

  ratio_t              fb_ratio;
  logic                sel_ok;
  logic [PROD_W-1:0]   prod;

  always_comb begin
    fb_ratio = '0;
    sel_ok   = 1'b0;
    for (int k = 0; k < NUM_DIV; k++) begin
      if (sel_q == SEL_W'(k)) begin
        fb_ratio = ratio_q[k];
        sel_ok   = 1'b1;
      end
    end
  end

  assign prod = PROD_W'(mult_q) * PROD_W'(fb_ratio);

  assign cfg_err_o = !sel_ok
                   || (mult_q == '0)
                   || (mult_q > mult_t'(MAX_MULT))
                   || (prod > PROD_W'(FB_PROD_MAX));

  assign ratio_o = ratio_q;
  assign inv_o   = inv_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/even_div_unit.sv
module even_div_unit
  import even_div_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  ratio_t ratio_i,
  input  logic   inv_i,
  output logic   clk_o,
  output logic   ok_o,
  output ratio_t phase_o,
  output ratio_t ratio_o
);
  ratio_t cnt_q, act_ratio_q;
  logic   act_inv_q, out_q;
  logic   act_ok, wrap;
  ratio_t nxt_cnt, nxt_ratio;
  logic   nxt_inv, nxt_ok;

  assign act_ok = ratio_ok(act_ratio_q);
  // illegal active ratio wraps every cycle so a fix is picked up at once
  assign wrap   = !run_i || !act_ok || (cnt_q == act_ratio_q - ratio_t'(1));

  always_comb begin
    nxt_cnt   = wrap ? '0      : cnt_q + ratio_t'(1);
    nxt_ratio = wrap ? ratio_i : act_ratio_q;
    nxt_inv   = wrap ? inv_i   : act_inv_q;
    nxt_ok    = ratio_ok(nxt_ratio);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      act_ratio_q <= RATIO_RST;
      act_inv_q   <= 1'b0;
      out_q       <= 1'b0;
    end else begin
      cnt_q       <= nxt_cnt;
      act_ratio_q <= nxt_ratio;
      act_inv_q   <= nxt_inv;
      out_q       <= nxt_ok && ((nxt_cnt < high_len(nxt_ratio)) ^ nxt_inv);
    end
  end

  assign clk_o   = out_q;
  assign ok_o    = act_ok;
  assign phase_o = cnt_q;
  assign ratio_o = act_ratio_q;
endmodule

// File: rtl/even_div_bank.sv
module even_div_bank
  import even_div_pkg::*;
#(
  parameter int NUM_DIV = 5,
  parameter int SEL_W   = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_DIV*RATIO_W-1:0]   cfg_ratio_i,
  input  logic [NUM_DIV-1:0]           cfg_inv_i,
  input  logic [SEL_W-1:0]             cfg_fb_sel_i,
  input  logic [MULT_W-1:0]            cfg_fb_mult_i,
  input  logic                         cfg_load_i,
  output logic [NUM_DIV-1:0]           clk_o,
  output logic                         fb_o,
  output logic [NUM_DIV-1:0]           div_err_o,
  output logic                         cfg_err_o
);
  ratio_t [NUM_DIV-1:0] sh_ratio;
  logic   [NUM_DIV-1:0] sh_inv;
  logic   [SEL_W-1:0]   sh_sel;
  logic                 run_q;
  logic   [NUM_DIV-1:0] unit_ok;
  ratio_t [NUM_DIV-1:0] unit_phase, unit_ratio;

  even_div_cfg #(.NUM_DIV(NUM_DIV), .SEL_W(SEL_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cfg_load_i),
    .ratio_i   (cfg_ratio_i),
    .inv_i     (cfg_inv_i),
    .sel_i     (cfg_fb_sel_i),
    .mult_i    (cfg_fb_mult_i),
    .ratio_o   (sh_ratio),
    .inv_o     (sh_inv),
    .sel_o     (sh_sel),
    .div_err_o (div_err_o),
    .cfg_err_o (cfg_err_o)
  );

  // common start so every divider wraps on the first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
    even_div_unit u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run_q),
      .ratio_i (sh_ratio[k]),
      .inv_i   (sh_inv[k]),
      .clk_o   (clk_o[k]),
      .ok_o    (unit_ok[k]),
      .phase_o (unit_phase[k]),
      .ratio_o (unit_ratio[k])
    );
  end

  always_comb begin
    fb_o = 1'b0;
    for (int k = 0; k < NUM_DIV; k++) begin
      if (sh_sel == SEL_W'(k)) fb_o = clk_o[k];
    end
  end
endmodule

// File: rtl/even_div_bank_chk.sv
module even_div_bank_chk
  import even_div_pkg::*;
#(
  parameter int NUM_DIV = 5,
  parameter int SEL_W   = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_load_i,
  input logic [NUM_DIV-1:0]   clk_o,
  input logic                 fb_o,
  input logic                 cfg_err_o,
  input logic                 run_q,
  input logic [NUM_DIV-1:0]   unit_ok,
  input ratio_t [NUM_DIV-1:0] unit_phase,
  input ratio_t [NUM_DIV-1:0] unit_ratio,
  input ratio_t [NUM_DIV-1:0] sh_ratio,
  input logic [SEL_W-1:0]     sh_sel
);
  for (genvar k = 0; k < NUM_DIV; k++) begin : g_k
    a_r1_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unit_ok[k] |-> (unit_phase[k] < unit_ratio[k]));

    a_r6_switch_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unit_phase[k] != '0) |-> $stable(unit_ratio[k]));

    a_r5_bad_ratio_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !unit_ok[k] |-> !clk_o[k]);
  end

  a_r10_load_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cfg_load_i) |-> $stable(sh_ratio));

  a_r7_aligned_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (clk_o == '1));

  a_r9_bad_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_sel >= SEL_W'(NUM_DIV)) |-> (cfg_err_o && !fb_o));
endmodule

bind even_div_bank even_div_bank_chk #(.NUM_DIV(NUM_DIV), .SEL_W(SEL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_load_i (cfg_load_i),
  .clk_o      (clk_o),
  .fb_o       (fb_o),
  .cfg_err_o  (cfg_err_o),
  .run_q      (run_q),
  .unit_ok    (unit_ok),
  .unit_phase (unit_phase),
  .unit_ratio (unit_ratio),
  .sh_ratio   (sh_ratio),
  .sh_sel     (sh_sel)
);

// File: tb/even_div_bank_tb_top.sv
`timescale 1ns/1ps
module even_div_bank_tb_top;
  localparam int N  = 5;
  localparam int RW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #2.5 clk = ~clk;

  logic [N*RW-1:0] ratio_in = '0;
  logic [N-1:0]    inv_in   = '0;
  logic [2:0]      sel_in   = '0;
  logic [5:0]      mult_in  = 6'd1;
  logic            load     = 1'b0;
  logic [N-1:0]    clk_out;
  logic            fb_out;
  logic [N-1:0]    derr;
  logic            cerr;

  even_div_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_ratio_i(ratio_in), .cfg_inv_i(inv_in),
    .cfg_fb_sel_i(sel_in), .cfg_fb_mult_i(mult_in), .cfg_load_i(load),
    .clk_o(clk_out), .fb_o(fb_out), .div_err_o(derr), .cfg_err_o(cerr)
  );

  int n_chk = 0;
  int n_err = 0;
  bit cmp_en = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int sh_r[N], sh_i[N], ac_r[N], ac_i[N], pos[N];
  int sh_sel, sh_mult;
  bit running;
  bit [N-1:0] exp_clk;

  function automatic bit legal(int r);
    return (r % 2 == 0) && r >= 2 && r <= 64;
  endfunction

  function automatic int hi_of(int r);
    if (r == 2 || r % 4 == 0) return r / 2;
    return r / 2 - 1;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < N; k++) begin
      sh_r[k] = 2; sh_i[k] = 0; ac_r[k] = 2; ac_i[k] = 0; pos[k] = 0;
    end
    sh_sel = 0; sh_mult = 1; running = 0; exp_clk = '0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      for (int k = 0; k < N; k++) begin
        if (!running || !legal(ac_r[k]) || pos[k] == ac_r[k] - 1) begin
          ac_r[k] = sh_r[k]; ac_i[k] = sh_i[k]; pos[k] = 0;
        end else pos[k]++;
        if (!legal(ac_r[k])) exp_clk[k] = 1'b0;
        else exp_clk[k] = (pos[k] < hi_of(ac_r[k])) ^ (ac_i[k] != 0);
      end
      running = 1;
      if (load) begin
        for (int k = 0; k < N; k++) begin
          sh_r[k] = int'(ratio_in[k*RW +: RW]);
          sh_i[k] = int'(inv_in[k]);
        end
        sh_sel = int'(sel_in); sh_mult = int'(mult_in);
      end
    end
  end

  function automatic bit exp_cerr();
    if (sh_sel >= N || sh_mult < 1 || sh_mult > 32) return 1'b1;
    return (sh_mult * sh_r[sh_sel]) > 64;
  endfunction

  always @(negedge clk) begin
    if (cmp_en) begin
      bit [N-1:0] ed;
      bit ef;
      for (int k = 0; k < N; k++) ed[k] = !legal(sh_r[k]);
      ef = (sh_sel < N) ? exp_clk[sh_sel] : 1'b0;
      chk(clk_out == exp_clk, "R1 R2 R3 R4 R6 model clk_o", int'(clk_out), int'(exp_clk));
      chk(fb_out == ef, "R8 model fb_o", int'(fb_out), int'(ef));
      chk(derr == ed, "R5 model div_err_o", int'(derr), int'(ed));
      chk(cerr == exp_cerr(), "R9 model cfg_err_o", int'(cerr), int'(exp_cerr()));
    end
  end

  // ---------------- stimulus ----------------
  task automatic load_cfg(int r0, int r1, int r2, int r3, int r4,
                          logic [N-1:0] inv, int sel, int mult);
    ratio_in = {RW'(r4), RW'(r3), RW'(r2), RW'(r1), RW'(r0)};
    inv_in = inv; sel_in = 3'(sel); mult_in = 6'(mult);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic measure(int k, int ehi, int eper, string tag);
    int hi = 0;
    int per = 0;
    bit prv;
    for (int g = 0; g < 200 && clk_out[k]; g++) @(negedge clk);
    for (int g = 0; g < 200 && !clk_out[k]; g++) @(negedge clk);
    for (int g = 0; g < 200; g++) begin
      hi += int'(clk_out[k]); per++;
      prv = clk_out[k];
      @(negedge clk);
      if (!prv && clk_out[k]) break;
    end
    chk(hi == ehi, {tag, " high time"}, hi, ehi);
    chk(per == eper, {tag, " period"}, per, eper);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(clk_out == '0, "R7 clk_o in reset", int'(clk_out), 0);
    chk(derr == '0 && cerr == 1'b0, "R7 flags in reset", int'({derr, cerr}), 0);
    rst_n = 1'b1;
    cmp_en = 1;
    @(negedge clk);
    chk(clk_out == 5'h1f, "R7 aligned first high", int'(clk_out), 31);

    // R1 R3 base patterns
    load_cfg(2, 4, 14, 64, 6, 5'b0, 0, 1);
    repeat (140) @(negedge clk);
    measure(0, 1, 2, "R3 ratio 2");
    measure(1, 2, 4, "R3 ratio 4");
    measure(2, 6, 14, "R3 ratio 14");
    measure(3, 32, 64, "R1 ratio 64");
    measure(4, 2, 6, "R3 ratio 6");

    // R4 inversion, R2 independence, R9 legal product 4*14
    load_cfg(2, 4, 14, 64, 10, 5'b00100, 2, 4);
    repeat (140) @(negedge clk);
    measure(2, 8, 14, "R4 ratio 14 inverted");
    measure(4, 4, 10, "R2 ratio 10 beside others");
    measure(1, 2, 4, "R2 ratio 4 unchanged");
    chk(cerr == 1'b0, "R9 product 56 legal", int'(cerr), 0);

    load_cfg(2, 4, 14, 64, 10, 5'b00100, 2, 5);
    @(negedge clk);
    chk(cerr == 1'b1, "R9 product 70", int'(cerr), 1);

    // R8 tap on divider 3, product 64
    load_cfg(2, 4, 14, 64, 10, 5'b0, 3, 1);
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (i % 10 == 0) chk(fb_out == clk_out[3], "R8 tap follows divider 3", int'(fb_out), int'(clk_out[3]));
    end
    chk(cerr == 1'b0, "R9 product 64 legal", int'(cerr), 0);

    // R9 illegal select and multiplier
    load_cfg(2, 4, 14, 64, 10, 5'b0, 6, 1);
    repeat (5) @(negedge clk);
    chk(cerr == 1'b1 && fb_out == 1'b0, "R9 select 6", int'({cerr, fb_out}), 2);
    load_cfg(2, 4, 14, 64, 10, 5'b0, 0, 0);
    @(negedge clk);
    chk(cerr == 1'b1, "R9 multiplier 0", int'(cerr), 1);
    load_cfg(2, 4, 14, 64, 10, 5'b0, 0, 33);
    @(negedge clk);
    chk(cerr == 1'b1, "R9 multiplier 33", int'(cerr), 1);
    load_cfg(2, 4, 14, 64, 10, 5'b0, 0, 32);
    @(negedge clk);
    chk(cerr == 1'b0, "R9 multiplier 32 times 2", int'(cerr), 0);

    // R5 illegal ratios
    load_cfg(2, 7, 14, 64, 10, 5'b0, 0, 1);
    chk(derr == 5'b00010, "R5 odd ratio flag", int'(derr), 2);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      chk(clk_out[1] == 1'b0, "R5 odd ratio holds low", int'(clk_out[1]), 0);
      @(negedge clk);
    end
    load_cfg(2, 66, 14, 64, 0, 5'b00010, 0, 1);
    chk(derr == 5'b10010, "R5 ratio 66 and 0 flags", int'(derr), 18);
    repeat (80) @(negedge clk);
    chk(clk_out[1] == 1'b0 && clk_out[4] == 1'b0, "R5 inverted illegal held low",
        int'({clk_out[1], clk_out[4]}), 0);

    // R10 inputs without strobe are ignored
    load_cfg(2, 4, 14, 64, 6, 5'b0, 0, 1);
    repeat (70) @(negedge clk);
    ratio_in[0 +: RW] = RW'(9);
    inv_in = 5'b11111;
    sel_in = 3'd7;
    repeat (20) @(negedge clk);
    chk(derr == '0 && cerr == 1'b0, "R10 no load keeps flags", int'({derr, cerr}), 0);
    measure(0, 1, 2, "R10 no load keeps ratio 2");

    // R6 mid-period change waits for wrap
    ratio_in = {RW'(6), RW'(64), RW'(14), RW'(4), RW'(2)};
    inv_in = '0; sel_in = '0;
    for (int g = 0; g < 200 && clk_out[3]; g++) @(negedge clk);
    for (int g = 0; g < 200 && !clk_out[3]; g++) @(negedge clk);
    repeat (40) @(negedge clk);
    load_cfg(2, 4, 14, 8, 6, 5'b0, 0, 1);
    for (int i = 0; i < 20; i++) begin
      chk(clk_out[3] == 1'b0, "R6 old low phase kept", int'(clk_out[3]), 0);
      @(negedge clk);
    end
    measure(3, 4, 8, "R6 new ratio 8 after wrap");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule